// File: doc/BRIEF.md
# Selectable Pin Event Flag Unit

This block tracks one selectable event channel for a processor. A 9-bit setting picks one of 64 input lines and a condition to watch for on it: a rising edge, a falling edge, any change, a low level or a high level. When the condition is seen, a sticky event flag is raised and held until software consumes it. Software consumes the flag in one of two ways. A poll strobe returns the flag and clears it. A wait request stalls until the flag is set, then clears it.

Clearing follows strict rules. When the detector fires in the same cycle as a clear, the set wins. Writing a new setting does not clear the flag. Only rewriting the value already held clears it. A flag left over from earlier use can therefore survive a reconfiguration, and software is expected to poll once after configuring in order to discard it.

The detector registers both its setting and the previous sample of the watched line. A new setting therefore acts one cycle after it is written, so a poll in the cycle directly after the write cannot yet see an event caused by that setting.

Top module: `pin_event_tracker`

## Requirements
- R1: The setting word holds the condition code in bits [8:6] and the index of the watched input line in bits [5:0]. Only the indexed line affects detection.
- R2: The edge codes are 1, 2 and 3.
  - Code 1 flags a 0-to-1 change of the watched line.
  - Code 2 flags a 1-to-0 change.
  - Code 3 flags either change.
  - An edge is a difference between the line in the current cycle and the line in the previous cycle.
- R3: The level codes are 4 and 5.
  - Code 4 flags every cycle in which the line is 0.
  - Code 5 flags every cycle in which the line is 1.
  - Codes 0, 6 and 7 never flag.
- R4: Once set, the flag stays set until a poll, a completed wait or an equal-value rewrite of the setting clears it.
- R5: A poll (`poll_req` high for one cycle) drives `poll_hit` high in that cycle when the flag is set, and clears the flag.
- R6: When a detection occurs in the same cycle as any clear, the flag stays set.
- R7: A wait request behaves as follows.
  - While the flag is clear, the request raises `wait_stall`.
  - In a cycle where the flag is set, `wait_done` rises in that same cycle and the flag is cleared.
- R8: Writing a setting that differs from the held one leaves the flag unchanged.
- R9: Writing a setting equal to the held one clears the flag.
- R10: A setting written in cycle N first detects in cycle N+1. Its event is therefore first returned by a poll in cycle N+2, and a poll in cycle N+1 returns 0.
- R11: Moving the watch to another line does not create an edge, even when the old and new lines hold different values.
- R12: Reset (`rst_n` low) clears the flag, the setting (to code 0, line 0) and the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| in_lines | input | 64 | Input lines that can be watched |
| cfg_we | input | 1 | Setting write strobe |
| cfg_word | input | 9 | Setting value: {code[2:0], line[5:0]} |
| poll_req | input | 1 | Poll strobe |
| poll_hit | output | 1 | Flag value returned to a poll in the same cycle |
| wait_req | input | 1 | Wait request, held until done |
| wait_stall | output | 1 | Wait pending: flag not yet set |
| wait_done | output | 1 | Wait satisfied in this cycle; flag consumed |

## Verification
The hardest state to reach from the ports is a stale flag that outlives a change of setting. To build it, the stimulus configures a high-level watch and lets the flag rise. It then lowers the line so that no new detection masks the result, and only then writes a different setting. A poll afterwards must still return 1.

A related case is the set-over-clear race. The stimulus reaches it by toggling the watched line in exactly the cycle that carries a poll, with change detection selected. Timing-sensitive cases, such as a poll in the cycle right after a setting write, are driven cycle by cycle.

// File: rtl/pev_pkg.sv
package pev_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 3'd0,
    MODE_RISE = 3'd1,
    MODE_FALL = 3'd2,
    MODE_ANY  = 3'd3,
    MODE_LOW  = 3'd4,
    MODE_HIGH = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } pev_mode_e;
endpackage

// File: rtl/pev_detect.sv
module pev_detect
  import pev_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int SEL_W     = $clog2(NUM_LINES),
  parameter int CFG_W     = MODE_W + SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_word,
  output logic [CFG_W-1:0]     cfg_q,
  output logic                 hit
);
  logic [CFG_W-1:0] cfg_d;
  logic [SEL_W-1:0] cur_sel;
  logic [SEL_W-1:0] nxt_sel;
  logic             smp_now;
  logic             prev_q;
  logic             prev_d;
  pev_mode_e        mode;

  // Next-state logic: the previous sample always follows the line that
  // will be selected after this edge, so a line switch brings no false edge.
  always_comb begin
    cfg_d   = cfg_we ? cfg_word : cfg_q;
    cur_sel = cfg_q[SEL_W-1:0];
    nxt_sel = cfg_d[SEL_W-1:0];
    smp_now = lines[cur_sel];
    prev_d  = lines[nxt_sel];
    mode    = pev_mode_e'(cfg_q[CFG_W-1:SEL_W]);
  end

  always_comb begin
    case (mode)
      MODE_RISE: hit = smp_now & ~prev_q;
      MODE_FALL: hit = ~smp_now & prev_q;
      MODE_ANY:  hit = smp_now ^ prev_q;
      MODE_LOW:  hit = ~smp_now;
      MODE_HIGH: hit = smp_now;
      default:   hit = 1'b0;
    endcase
  end

  // Registers: the setting has an explicit enable, the sample loads every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/pev_flag.sv
module pev_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic poll_req,
  input  logic wait_req,
  input  logic cfg_rewrite,
  output logic flag_q,
  output logic poll_hit,
  output logic wait_stall,
  output logic wait_done
);
  logic clr;
  logic flag_d;

  always_comb begin
    poll_hit   = poll_req & flag_q;
    wait_done  = wait_req & flag_q;
    wait_stall = wait_req & ~flag_q;
    clr        = poll_req | wait_done | cfg_rewrite;
    // Set takes priority over any clear in the same cycle.
    flag_d     = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/pin_event_tracker.sv
module pin_event_tracker
  import pev_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int SEL_W    = $clog2(NUM_LINES),
  localparam int CFG_W    = MODE_W + SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] in_lines,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_word,
  input  logic                 poll_req,
  output logic                 poll_hit,
  input  logic                 wait_req,
  output logic                 wait_stall,
  output logic                 wait_done
);
  logic [CFG_W-1:0] cfg_q;
  logic             evt_hit;
  logic             flag_q;
  logic             cfg_rewrite;

  assign cfg_rewrite = cfg_we & (cfg_word == cfg_q);

  pev_detect #(
    .NUM_LINES (NUM_LINES),
    .SEL_W     (SEL_W),
    .CFG_W     (CFG_W)
  ) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (in_lines),
    .cfg_we   (cfg_we),
    .cfg_word (cfg_word),
    .cfg_q    (cfg_q),
    .hit      (evt_hit)
  );

  pev_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (evt_hit),
    .poll_req    (poll_req),
    .wait_req    (wait_req),
    .cfg_rewrite (cfg_rewrite),
    .flag_q      (flag_q),
    .poll_hit    (poll_hit),
    .wait_stall  (wait_stall),
    .wait_done   (wait_done)
  );
endmodule

// File: rtl/pev_chk.sv
module pev_chk #(
  parameter int CFG_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_word,
  input logic [CFG_W-1:0] cfg_q,
  input logic             poll_req,
  input logic             wait_req,
  input logic             wait_done,
  input logic             evt_hit,
  input logic             flag_q
);
  // R1
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_word));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !poll_req && !wait_req && !(cfg_we && cfg_word == cfg_q) |=> flag_q);

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(evt_hit));

  // R5
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req && !evt_hit |=> !flag_q);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> flag_q);

  // R7
  wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done && !evt_hit |=> !flag_q);

  // R8
  stale_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && cfg_we && cfg_word != cfg_q && !poll_req && !wait_req |=> flag_q);

  // R9
  same_cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_word == cfg_q && !evt_hit |=> !flag_q);
endmodule

bind pin_event_tracker pev_chk #(.CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_word  (cfg_word),
  .cfg_q     (cfg_q),
  .poll_req  (poll_req),
  .wait_req  (wait_req),
  .wait_done (wait_done),
  .evt_hit   (evt_hit),
  .flag_q    (flag_q)
);

// File: tb/pin_event_tracker_test.sv
module pin_event_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL         = 64;
  localparam int NVEC       = 13;
  localparam logic [NL-1:0] BG = 64'hA5A5_5A5A_C3C3_3C3C;
  // {code[2:0], line[5:0], before, after, expected poll result}
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd1, 6'd3,  1'b0, 1'b1, 1'b1},
    {3'd1, 6'd3,  1'b1, 1'b0, 1'b0},
    {3'd2, 6'd63, 1'b1, 1'b0, 1'b1},
    {3'd2, 6'd63, 1'b0, 1'b1, 1'b0},
    {3'd3, 6'd0,  1'b0, 1'b1, 1'b1},
    {3'd3, 6'd0,  1'b1, 1'b1, 1'b0},
    {3'd4, 6'd17, 1'b1, 1'b0, 1'b1},
    {3'd4, 6'd17, 1'b1, 1'b1, 1'b0},
    {3'd5, 6'd40, 1'b0, 1'b1, 1'b1},
    {3'd5, 6'd40, 1'b0, 1'b0, 1'b0},
    {3'd0, 6'd5,  1'b0, 1'b1, 1'b0},
    {3'd6, 6'd5,  1'b0, 1'b1, 1'b0},
    {3'd7, 6'd5,  1'b1, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] in_lines;
  logic          cfg_we;
  logic [8:0]    cfg_word;
  logic          poll_req;
  logic          wait_req;
  logic          poll_hit;
  logic          wait_stall;
  logic          wait_done;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_tracker uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_lines   (in_lines),
    .cfg_we     (cfg_we),
    .cfg_word   (cfg_word),
    .poll_req   (poll_req),
    .poll_hit   (poll_hit),
    .wait_req   (wait_req),
    .wait_stall (wait_stall),
    .wait_done  (wait_done)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_lines = '0; cfg_we = 1'b0; cfg_word = '0;
    poll_req = 1'b0; wait_req = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;

    // R12: reset state, flag clear
    step(); poll_req = 1'b1; #1 check("R12 poll after reset", poll_hit, 1'b0);
    step(); poll_req = 1'b0; wait_req = 1'b1;
    #1 check("R7 stall with clear flag", wait_stall, 1'b1);
    check("R7 no done with clear flag", wait_done, 1'b0);
    step(); wait_req = 1'b0;

    // R1, R2, R3: table of codes, lines and input transitions
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] m; logic [5:0] l; logic b, a, e;
      {m, l, b, a, e} = VEC[i];
      step(); in_lines = BG; in_lines[l] = b; cfg_we = 1'b1; cfg_word = {m, l};
      step(); cfg_we = 1'b0;
      step(); poll_req = 1'b1;
      step(); poll_req = 1'b0; in_lines[l] = a;
      step(); step();
      step(); poll_req = 1'b1;
      #1 check((m >= 3'd1 && m <= 3'd3) ? "R1,R2 vector" : "R1,R3 vector", poll_hit, e);
      step(); poll_req = 1'b0;
    end
    step(); poll_req = 1'b1;
    step(); poll_req = 1'b0;

    // R8: stale flag survives a different setting (also R4 stickiness)
    step(); in_lines = '0; in_lines[2] = 1'b1; cfg_we = 1'b1; cfg_word = {3'd5, 6'd2};
    step(); cfg_we = 1'b0;
    step(); poll_req = 1'b1;
    step(); poll_req = 1'b0;
    step(); in_lines[2] = 1'b0;
    step(); step();
    step(); cfg_we = 1'b1; cfg_word = {3'd0, 6'd2};
    step(); cfg_we = 1'b0;
    step(); step(); poll_req = 1'b1;
    #1 check("R8 stale flag kept", poll_hit, 1'b1);
    step(); #1 check("R5 poll cleared flag", poll_hit, 1'b0);
    step(); poll_req = 1'b0;

    // R9: equal-value rewrite clears the flag
    step(); in_lines[2] = 1'b1; cfg_we = 1'b1; cfg_word = {3'd5, 6'd2};
    step(); cfg_we = 1'b0;
    step(); in_lines[2] = 1'b0;
    step(); cfg_we = 1'b1; cfg_word = {3'd5, 6'd2};
    step(); cfg_we = 1'b0; poll_req = 1'b1;
    #1 check("R9 rewrite cleared flag", poll_hit, 1'b0);
    step(); poll_req = 1'b0;

    // R6: poll coinciding with a new edge leaves the flag set
    step(); in_lines[4] = 1'b0; cfg_we = 1'b1; cfg_word = {3'd3, 6'd4};
    step(); cfg_we = 1'b0;
    step(); poll_req = 1'b1;
    step(); poll_req = 1'b0; in_lines[4] = 1'b1;
    step(); poll_req = 1'b1; in_lines[4] = 1'b0;
    #1 check("R6 poll returns set flag", poll_hit, 1'b1);
    step(); #1 check("R6 flag survives coinciding poll", poll_hit, 1'b1);
    step(); #1 check("R5 flag cleared after poll", poll_hit, 1'b0);
    step(); poll_req = 1'b0;

    // R10: poll in cycle after write does not see the new setting
    step(); in_lines[11] = 1'b1; cfg_we = 1'b1; cfg_word = {3'd5, 6'd11};
    step(); cfg_we = 1'b0; poll_req = 1'b1;
    #1 check("R10 poll right after write", poll_hit, 1'b0);
    step(); #1 check("R10 poll two cycles after write", poll_hit, 1'b1);
    step(); poll_req = 1'b0; in_lines[11] = 1'b0;
    step(); poll_req = 1'b1;
    step(); poll_req = 1'b0;

    // R7: wait completes at once when set, stalls otherwise
    step(); in_lines[11] = 1'b1;
    step(); in_lines[11] = 1'b0;
    step(); wait_req = 1'b1;
    #1 check("R7 done same cycle", wait_done, 1'b1);
    check("R7 no stall when set", wait_stall, 1'b0);
    step(); #1 check("R7 stall after consume", wait_stall, 1'b1);
    step(); in_lines[11] = 1'b1;
    #1 check("R7 stall until flag registered", wait_stall, 1'b1);
    step(); in_lines[11] = 1'b0;
    #1 check("R7 done after event", wait_done, 1'b1);
    step(); wait_req = 1'b0; poll_req = 1'b1;
    #1 check("R7 wait cleared flag", poll_hit, 1'b0);
    step(); poll_req = 1'b0;

    // R11: switching watched line makes no false edge
    step(); in_lines[20] = 1'b0; in_lines[21] = 1'b1; cfg_we = 1'b1; cfg_word = {3'd1, 6'd20};
    step(); cfg_we = 1'b0;
    step(); poll_req = 1'b1;
    step(); poll_req = 1'b0; cfg_we = 1'b1; cfg_word = {3'd1, 6'd21};
    step(); cfg_we = 1'b0;
    step(); step(); poll_req = 1'b1;
    #1 check("R11 no edge on line switch", poll_hit, 1'b0);
    step(); poll_req = 1'b0; in_lines[21] = 1'b0;
    step(); in_lines[21] = 1'b1;
    step(); step(); poll_req = 1'b1;
    #1 check("R11 real edge on new line", poll_hit, 1'b1);
    step(); poll_req = 1'b0;

    // R12: reset clears flag and setting
    step(); in_lines[30] = 1'b1; cfg_we = 1'b1; cfg_word = {3'd5, 6'd30};
    step(); cfg_we = 1'b0;
    step(); rst_n = 1'b0;
    step(); rst_n = 1'b1;
    step(); step(); poll_req = 1'b1;
    #1 check("R12 reset cleared flag and setting", poll_hit, 1'b0);
    step(); poll_req = 1'b0;

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule